// File: doc/BRIEF.md
# NAND Flash Host Window Controller

This block lets a host reach a NAND flash device through single-byte accesses. A fixed configuration page holds a window enable and a 32-bit window base. When the window is enabled and the page part of the host address equals the programmed base, the low eight address bits select one of the window's registers. These registers are a byte-wide data port, a pin-control (mode) register, a constant status byte, an interrupt status register and an interrupt mask register.

Software drives the flash control lines (command latch, address latch, chip select, write protect) directly by writing the mode register. Each data-port access makes one flash bus byte cycle, marked by a single-cycle write or read strobe. A one-cycle ECC-clear pulse is issued for the mode commands that restart ECC accumulation. An interrupt line combines the status and mask registers through a global enable bit in the mask.

Host accesses use a synchronous byte bus. `hostWr` or `hostRd` is held for one cycle, and the host asserts at most one of them at a time. Read data appears on `hostRdata` in the cycle after the read and holds until the next read.

Top module: `nand_host_window`

## Requirements
- R1: After synchronous reset, every register (enable, base, mode, interrupt status, interrupt mask) is 0. This gives `irq`=0, `flashCeN`=1, `flashCle`=`flashAle`=`flashWp`=0, no strobes, `eccClear`=0 and `hostRdata`=0.
- R2: At configuration offset 0x04, bit 1 of a written byte sets the window enable. Reading that offset returns 0x02 when the window is enabled and 0x00 when it is not.
- R3: Configuration offsets 0x10..0x13 hold the window base one byte per offset. Offset 0x10+k holds base bits 8k+7..8k, and each byte reads back what was written.
- R4: A window access hits only when the enable is set and the host address with its low 8 bits forced to zero equals the full 32-bit base. Accesses to the configuration page (address bits 31:8 equal to the configuration page, 0x000001 by default) always go to configuration space, even when the base points there. A window access that misses changes no state and reads 0.
- R5: A write to window offsets 0x00..0x03 gives `flashWe`=1 for that cycle only, puts the written byte on `flashDout`, and sets interrupt status bit 0.
- R6: A read of window offsets 0x00..0x03 gives `flashRe`=1 for that cycle only. The byte present on `flashDin` in that cycle is returned on `hostRdata`.
- R7: Window offset 0x04 is the mode register and reads back as written. Bit 0 drives `flashCle`, bit 1 drives `flashAle` and bit 7 drives `flashWp`. `flashCeN` is the inverse of bit 4.
- R8: A mode write whose bits 6:5 are 11 or 01 produces `eccClear`=1 for exactly the following cycle. Values 10 and 00 produce no pulse.
- R9: Window offset 0x05 always reads 0x14.
- R10: Window offsets 0x06 (interrupt status) and 0x07 (interrupt mask) are written and read back as whole bytes. `irq` is 1 exactly when mask bit 7 is 1 and mask AND status is non-zero.
- R11: Reads return data in the cycle after `hostRd`. Unassigned offsets in the configuration page or the window read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostAddr | input | 32 | Host byte address |
| hostWr | input | 1 | Host write, one cycle |
| hostRd | input | 1 | Host read, one cycle |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Read byte, valid the cycle after `hostRd` |
| flashDin | input | 8 | Byte from the flash bus |
| flashDout | output | 8 | Byte toward the flash bus |
| flashWe | output | 1 | Flash write strobe |
| flashRe | output | 1 | Flash read strobe |
| flashCle | output | 1 | Command latch enable |
| flashAle | output | 1 | Address latch enable |
| flashCeN | output | 1 | Active-low chip enable |
| flashWp | output | 1 | Write-protect line |
| eccClear | output | 1 | One-cycle ECC accumulator clear |
| irq | output | 1 | Interrupt request |

## Verification
The bench writes a valid window address while the enable is clear, then reads back the mode register. A decoder that ignored the enable would leave CLE raised and return the stale byte. It sets the low byte of the base to a non-zero value, which must disable every hit; a design comparing only the upper bits would keep answering. It also points the base at the configuration page to confirm that configuration space wins there.

The interrupt checks cover a mask that selects a set status bit but has bit 7 clear, and a mask with bit 7 set whose selection does not overlap the status. A design that used only the global bit, or only the overlap, would raise `irq` wrongly in one of these cases. All four ECC command codes are tried, so a decoder that pulsed on the read command or missed the enable command is caught. The bench also measures the pulse and strobe widths against a single cycle.

// File: rtl/nwc_pkg.sv
package nwc_pkg;
  parameter int NWC_ADDR_W = 32;
  parameter int NWC_OFS_W  = 8;
  localparam int NWC_LANES  = NWC_ADDR_W / 8;
  localparam int NWC_LANE_W = $clog2(NWC_LANES);

  // configuration page offsets
  localparam logic [NWC_OFS_W-1:0] CFG_OFS_CMD  = 8'h04;
  localparam logic [NWC_OFS_W-1:0] CFG_OFS_BASE = 8'h10;
  // window offsets
  localparam logic [NWC_OFS_W-1:0] WIN_OFS_MODE = 8'h04;
  localparam logic [NWC_OFS_W-1:0] WIN_OFS_STAT = 8'h05;
  localparam logic [NWC_OFS_W-1:0] WIN_OFS_ISR  = 8'h06;
  localparam logic [NWC_OFS_W-1:0] WIN_OFS_IMR  = 8'h07;
  localparam logic [7:0]           STATUS_VALUE = 8'h14;

  typedef enum logic [2:0] {
    RS_ZERO, RS_CMD, RS_BASE, RS_DATA, RS_MODE, RS_STAT, RS_ISR, RS_IMR
  } rdSel_e;

  typedef struct packed {
    logic                  cmdWr;
    logic                  baseWr;
    logic [NWC_LANE_W-1:0] lane;
    logic                  dataWr;
    logic                  dataRd;
    logic                  modeWr;
    logic                  isrWr;
    logic                  imrWr;
    logic                  rdEn;
    rdSel_e                rdSel;
  } nwcStb_t;
endpackage

// File: rtl/nwc_ctrl.sv
module nwc_ctrl
  import nwc_pkg::*;
#(
  parameter logic [NWC_ADDR_W-NWC_OFS_W-1:0] CFG_PAGE = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NWC_ADDR_W-1:0] hostAddr,
  input  logic                  hostWr,
  input  logic                  hostRd,
  input  logic                  winEn,
  input  logic [NWC_ADDR_W-1:0] winBase,
  output nwcStb_t               stb
);
  localparam int PAGE_W = NWC_ADDR_W - NWC_OFS_W;

  logic [NWC_OFS_W-1:0] ofs;
  logic [PAGE_W-1:0]    page;
  logic                 cfgHit;
  logic                 winHit;

  assign ofs    = hostAddr[NWC_OFS_W-1:0];
  assign page   = hostAddr[NWC_ADDR_W-1:NWC_OFS_W];
  assign cfgHit = (page == CFG_PAGE);
  // the base low byte takes part in the compare: a non-zero low byte never hits
  assign winHit = !cfgHit && winEn && ({page, {NWC_OFS_W{1'b0}}} == winBase);

  always_comb begin
    stb       = '0;
    stb.rdEn  = hostRd;
    stb.rdSel = RS_ZERO;
    if (cfgHit) begin
      if (ofs == CFG_OFS_CMD) begin
        stb.cmdWr = hostWr;
        stb.rdSel = RS_CMD;
      end else if (ofs[NWC_OFS_W-1:NWC_LANE_W] == CFG_OFS_BASE[NWC_OFS_W-1:NWC_LANE_W]) begin
        stb.baseWr = hostWr;
        stb.lane   = ofs[NWC_LANE_W-1:0];
        stb.rdSel  = RS_BASE;
      end
    end else if (winHit) begin
      if (ofs[NWC_OFS_W-1:2] == '0) begin
        stb.dataWr = hostWr;
        stb.dataRd = hostRd;
        stb.rdSel  = RS_DATA;
      end else begin
        unique case (ofs)
          WIN_OFS_MODE: begin stb.modeWr = hostWr; stb.rdSel = RS_MODE; end
          WIN_OFS_STAT: stb.rdSel = RS_STAT;
          WIN_OFS_ISR:  begin stb.isrWr = hostWr; stb.rdSel = RS_ISR; end
          WIN_OFS_IMR:  begin stb.imrWr = hostWr; stb.rdSel = RS_IMR; end
          default:      stb.rdSel = RS_ZERO;
        endcase
      end
    end
  end

  AST_WIN_GATED: assert property (@(posedge clk) disable iff (rst)
    !winEn |-> !(stb.dataWr || stb.dataRd || stb.modeWr || stb.isrWr || stb.imrWr)); // R4
  AST_DATA_PAGE: assert property (@(posedge clk) disable iff (rst)
    (stb.dataWr || stb.dataRd) |-> (hostAddr[NWC_ADDR_W-1:NWC_OFS_W] == winBase[NWC_ADDR_W-1:NWC_OFS_W])); // R4
endmodule

// File: rtl/nwc_dpath.sv
module nwc_dpath
  import nwc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  nwcStb_t               stb,
  input  logic [7:0]            hostWdata,
  input  logic [7:0]            flashDin,
  output logic                  winEn,
  output logic [NWC_ADDR_W-1:0] winBase,
  output logic [7:0]            hostRdata,
  output logic [7:0]            flashDout,
  output logic                  flashWe,
  output logic                  flashRe,
  output logic                  flashCle,
  output logic                  flashAle,
  output logic                  flashCeN,
  output logic                  flashWp,
  output logic                  eccClear,
  output logic                  irq
);
  logic [7:0] baseByte [NWC_LANES];
  logic [7:0] modeReg;
  logic [7:0] isrReg;
  logic [7:0] imrReg;
  logic [7:0] rdVal;

  always_ff @(posedge clk) begin
    if (rst) winEn <= 1'b0;
    else if (stb.cmdWr) winEn <= hostWdata[1];
  end

  for (genvar g = 0; g < NWC_LANES; g++) begin : gLane
    always_ff @(posedge clk) begin
      if (rst) baseByte[g] <= '0;
      else if (stb.baseWr && (stb.lane == NWC_LANE_W'(g))) baseByte[g] <= hostWdata;
    end
    assign winBase[8*g +: 8] = baseByte[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeReg  <= '0;
      isrReg   <= '0;
      imrReg   <= '0;
      eccClear <= 1'b0;
    end else begin
      if (stb.modeWr) modeReg <= hostWdata;
      if (stb.imrWr)  imrReg  <= hostWdata;
      if (stb.isrWr)       isrReg    <= hostWdata;
      else if (stb.dataWr) isrReg[0] <= 1'b1;
      // ECC commands 11 and 01 both carry bit 5 set
      eccClear <= stb.modeWr && hostWdata[5];
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      RS_CMD:  rdVal = {6'b0, winEn, 1'b0};
      RS_BASE: rdVal = baseByte[stb.lane];
      RS_DATA: rdVal = flashDin;
      RS_MODE: rdVal = modeReg;
      RS_STAT: rdVal = STATUS_VALUE;
      RS_ISR:  rdVal = isrReg;
      RS_IMR:  rdVal = imrReg;
      default: rdVal = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) hostRdata <= '0;
    else if (stb.rdEn) hostRdata <= rdVal;
  end

  assign flashDout = hostWdata;
  assign flashWe   = stb.dataWr;
  assign flashRe   = stb.dataRd;
  assign flashCle  = modeReg[0];
  assign flashAle  = modeReg[1];
  assign flashCeN  = ~modeReg[4];
  assign flashWp   = modeReg[7];
  assign irq       = imrReg[7] && |(imrReg & isrReg);

  AST_ISR_SET: assert property (@(posedge clk) disable iff (rst)
    (stb.dataWr && !stb.isrWr) |=> isrReg[0]); // R5
  AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    stb.dataRd |=> (hostRdata == $past(flashDin))); // R6
  AST_CE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    stb.modeWr |=> (flashCeN == !$past(hostWdata[4]))); // R7
  AST_ECC_CAUSE: assert property (@(posedge clk) disable iff (rst)
    eccClear |-> $past(stb.modeWr)); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(stb.isrWr || stb.imrWr || stb.dataWr)); // R10
endmodule

// File: rtl/nand_host_window.sv
module nand_host_window
  import nwc_pkg::*;
#(
  parameter logic [NWC_ADDR_W-NWC_OFS_W-1:0] CFG_PAGE = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NWC_ADDR_W-1:0] hostAddr,
  input  logic                  hostWr,
  input  logic                  hostRd,
  input  logic [7:0]            hostWdata,
  output logic [7:0]            hostRdata,
  input  logic [7:0]            flashDin,
  output logic [7:0]            flashDout,
  output logic                  flashWe,
  output logic                  flashRe,
  output logic                  flashCle,
  output logic                  flashAle,
  output logic                  flashCeN,
  output logic                  flashWp,
  output logic                  eccClear,
  output logic                  irq
);
  nwcStb_t               stb;
  logic                  winEn;
  logic [NWC_ADDR_W-1:0] winBase;

  nwc_ctrl #(.CFG_PAGE(CFG_PAGE)) uCtrl (
    .clk(clk), .rst(rst), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .winEn(winEn), .winBase(winBase), .stb(stb)
  );

  nwc_dpath uDpath (
    .clk(clk), .rst(rst), .stb(stb), .hostWdata(hostWdata), .flashDin(flashDin),
    .winEn(winEn), .winBase(winBase), .hostRdata(hostRdata), .flashDout(flashDout),
    .flashWe(flashWe), .flashRe(flashRe), .flashCle(flashCle), .flashAle(flashAle),
    .flashCeN(flashCeN), .flashWp(flashWp), .eccClear(eccClear), .irq(irq)
  );
endmodule

// File: tb/tb_nand_host_window.sv
module tb_nand_host_window;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic [31:0] hostAddr = '0;
  logic        hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0]  hostWdata = '0, flashDin = '0;
  logic [7:0]  hostRdata, flashDout;
  logic        flashWe, flashRe, flashCle, flashAle, flashCeN, flashWp, eccClear, irq;

  nand_host_window dut (.*);

  localparam logic [31:0] CFG = 32'h0000_0100;
  localparam logic [31:0] WB  = 32'h4000_1200;

  int checks = 0, errors = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       rdSeen = 1'b0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: compare read data one cycle after each sampled read
  always @(posedge clk) rdSeen <= hostRd & ~rst;
  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) chk("R11 unexpected read", 1, 0);
      else begin
        automatic logic [7:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        chk(t, hostRdata, e);
      end
    end
  end

  task automatic wr(input logic [31:0] a, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    hostAddr = a; hostRd = 1'b1;
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 irq", irq, 0); chk("R1 ceN", flashCeN, 1); chk("R1 cle", flashCle, 0);
    chk("R1 ecc", eccClear, 0); chk("R1 we", flashWe, 0); chk("R1 rdata", hostRdata, 0);
    rd(CFG + 4, 8'h00, "R1 enable");
    rd(CFG + 19, 8'h00, "R1 base");

    wr(CFG + 16, 8'h00); wr(CFG + 17, 8'h12); wr(CFG + 18, 8'h00); wr(CFG + 19, 8'h40);
    // disabled window: the mode write must be ignored
    wr(WB + 4, 8'h13); #1;
    chk("R4 cle disabled", flashCle, 0); chk("R4 ceN disabled", flashCeN, 1);
    rd(WB + 4, 8'h00, "R4 disabled read");

    wr(CFG + 4, 8'hFD); rd(CFG + 4, 8'h00, "R2 bit1 clear");
    wr(CFG + 4, 8'h02); rd(CFG + 4, 8'h02, "R2 enabled");
    rd(CFG + 16, 8'h00, "R3 byte0"); rd(CFG + 17, 8'h12, "R3 byte1");
    rd(CFG + 19, 8'h40, "R3 byte3");
    rd(WB + 4, 8'h00, "R4 earlier write had no effect");

    wr(WB + 4, 8'h93); #1;
    chk("R7 cle", flashCle, 1); chk("R7 ale", flashAle, 1); chk("R7 ceN", flashCeN, 0);
    chk("R7 wp", flashWp, 1); chk("R8 cmd00", eccClear, 0);
    rd(WB + 4, 8'h93, "R7 readback");
    wr(WB + 4, 8'h60); #1; chk("R8 cmd11", eccClear, 1); chk("R7 ceN off", flashCeN, 1);
    @(negedge clk); #1; chk("R8 pulse width", eccClear, 0);
    wr(WB + 4, 8'h20); #1; chk("R8 cmd01", eccClear, 1);
    wr(WB + 4, 8'h40); #1; chk("R8 cmd10", eccClear, 0);
    wr(WB + 4, 8'h00); #1; chk("R8 cmd00 again", eccClear, 0);
    rd(WB + 5, 8'h14, "R9 status");

    // data write strobe
    @(negedge clk);
    hostAddr = WB + 2; hostWdata = 8'hA5; hostWr = 1'b1; #1;
    chk("R5 we high", flashWe, 1); chk("R5 dout", flashDout, 8'hA5); chk("R5 re low", flashRe, 0);
    @(negedge clk); hostWr = 1'b0; #1;
    chk("R5 we one cycle", flashWe, 0);
    rd(WB + 6, 8'h01, "R5 isr bit0");
    chk("R10 no mask", irq, 0);

    wr(WB + 7, 8'h01); #1; chk("R10 global bit clear", irq, 0);
    wr(WB + 7, 8'h81); #1; chk("R10 enabled", irq, 1);
    rd(WB + 7, 8'h81, "R10 imr readback");
    wr(WB + 6, 8'h00); #1; chk("R10 isr cleared", irq, 0);
    wr(WB + 6, 8'h02); #1; chk("R10 no overlap", irq, 0);
    wr(WB + 7, 8'h82); #1; chk("R10 overlap", irq, 1);
    rd(WB + 6, 8'h02, "R10 isr readback");

    // data read strobe
    @(negedge clk);
    hostAddr = WB + 3; hostRd = 1'b1; flashDin = 8'h3C;
    expQ.push_back(8'h3C); tagQ.push_back("R6 read capture");
    #1; chk("R6 re high", flashRe, 1); chk("R6 we low", flashWe, 0);
    @(negedge clk); hostRd = 1'b0; flashDin = 8'hFF; #1;
    chk("R6 re one cycle", flashRe, 0);
    flashDin = 8'hC3;
    rd(WB, 8'hC3, "R6 offset0");

    rd(WB + 32'h100 + 4, 8'h00, "R4 other page read");
    wr(WB + 32'h100 + 6, 8'hFF);
    rd(WB + 6, 8'h02, "R4 other page no effect");
    rd(WB + 8, 8'h00, "R11 window unassigned");
    rd(CFG + 32, 8'h00, "R11 config unassigned");

    wr(CFG + 16, 8'h01);
    rd(WB + 5, 8'h00, "R4 base low byte set");
    wr(CFG + 16, 8'h00);
    rd(WB + 5, 8'h14, "R9 restored");

    wr(CFG + 17, 8'h01); wr(CFG + 19, 8'h00);
    rd(CFG + 4, 8'h02, "R4 config page wins");
    wr(CFG + 17, 8'h12); wr(CFG + 19, 8'h40);
    wr(CFG + 4, 8'h00);
    rd(WB + 5, 8'h00, "R4 disabled again");

    repeat (3) @(negedge clk);
    chk("R11 drain", expQ.size(), 0);
    summary();
  end
endmodule